// File: doc/BRIEF.md
# Two-Wire Display Memory Slave

This block is the host-facing side of a small status-panel driver. It listens on a two-wire I2C bus (SCL and SDA, with SDA modelled as a separate input and a pull-low output, as an open-drain pin is), answers to one fixed 7-bit device address, and keeps a 12-byte display memory plus a short mode register. The mode fields and the whole memory are presented in parallel to the panel drive sequencer, which reads them every cycle.

A host updates the panel with a write transfer: after the address, the first byte sets the mode register and loads the byte pointer, and every further byte lands in the memory at the pointer, which then advances. A host reads the memory back either by writing a mode byte and issuing a repeated start into a read, or by reading directly from wherever the pointer was left. The pointer advances on every byte moved in either direction and wraps from the last location to the first.

SCL and SDA are brought into the block's own faster clock with two flip-flops each; start and stop conditions are recognised as SDA edges while SCL is high. No clock stretching, general call or arbitration is provided.

Top module: `disp_i2c_slave`

## Requirements
- R1: After reset the display-off flag, frame-rate select, blink-rate select, byte pointer and all 12 memory bytes are zero, and SDA is not pulled low.
- R2: The slave pulls SDA low in the acknowledge slot of an address byte whose upper seven bits are 0111001, and in the acknowledge slot of every byte written to it after such an address with the low (R/W) bit at 0.
- R3: After an address byte with any other upper seven bits, the slave never pulls SDA low and no register or memory byte changes until the next start condition; a start condition that follows is served normally.
- R4: The first byte of a write transfer sets display-off from bit 7, the 2-bit frame-rate select from bits 6:5 and the blink-rate select from bit 4, and loads the pointer from bits 3:0.
- R5: Each later byte of a write transfer is stored in memory byte number pointer, after which the pointer increases by one.
- R6: Pointer increments, on writes and on reads alike, take the value 11 to 0.
- R7: A pointer value of 12 to 15 in the first written byte loads the pointer with 0.
- R8: In a transfer made of a write of the first byte, a repeated start and the address with bit 0 at 1, the slave sends, most significant bit first, the memory bytes starting at the newly loaded pointer, one per byte acknowledged by the host.
- R9: A read transfer that begins directly after a start sends the memory bytes starting at the pointer left by the previous transfer.
- R10: Every byte sent advances the pointer by one, the last (not acknowledged) byte included; after the host leaves a byte unacknowledged the slave stops driving SDA.
- R11: Memory byte n appears on bits 8n+7 down to 8n of the parallel memory output at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| dispOff | output | 1 | Display-off flag from the mode register |
| frameSel | output | 2 | Frame-rate select from the mode register |
| blinkSel | output | 1 | Blink-rate select from the mode register |
| memPtr | output | 4 | Current byte pointer |
| memFlat | output | 96 | All 12 memory bytes, byte n in bits 8n+7:8n |

## Verification
The mode byte is swept through all sixteen pointer values with the upper bits varying alongside, which separates correct field placement from swapped bits and shows the out-of-range pointers folding to zero. Memory is filled with a byte pattern in which every location differs, so a misplaced write or a wrong read index shows as a wrong value rather than an accidental match. Combined reads are started from every pointer, including the last two so that the wrap is crossed mid-transfer, and a direct read continues from the left-over pointer. Foreign write and read addresses, followed by a repeated start to the right address, tell apart a slave that ignores strangers from one that stays deaf after them.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  localparam int PTR_W = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              cmdWe;
    logic              memWe;
    logic              ptrInc;
    logic [BYTE_W-1:0] wrData;
  } busStrobe_t;
endpackage

// File: rtl/disp_i2c_ctrl.sv
module disp_i2c_ctrl
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  output busStrobe_t        strobe,
  output logic              sdaDriveLow
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_SKIP
  } ctrlState_t;

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_W);

  logic [1:0] sclSyncQ, sdaSyncQ;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, startDet, stopDet;

  ctrlState_t        state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              addrPhase, isRead, firstByte, masterAck, driveLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSyncQ <= 2'b11;
      sdaSyncQ <= 2'b11;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclSyncQ <= {sclSyncQ[0], sclIn};
      sdaSyncQ <= {sdaSyncQ[0], sdaIn};
      sclPrev  <= sclSyncQ[1];
      sdaPrev  <= sdaSyncQ[1];
    end
  end

  assign sclNow   = sclSyncQ[1];
  assign sdaNow   = sdaSyncQ[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      addrPhase <= 1'b0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
      driveLow  <= 1'b0;
      strobe    <= '0;
    end else begin
      strobe <= '0;
      if (startDet) begin
        state     <= ST_RX;
        bitCnt    <= '0;
        addrPhase <= 1'b1;
        driveLow  <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        driveLow <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != FULL_CNT) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == FULL_CNT) begin
              bitCnt <= '0;
              if (addrPhase) begin
                addrPhase <= 1'b0;
                if (shiftReg[7:1] == DEV_ADDR) begin
                  isRead    <= shiftReg[0];
                  firstByte <= 1'b1;
                  driveLow  <= 1'b1;
                  state     <= ST_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                strobe.wrData <= shiftReg;
                if (firstByte) begin
                  strobe.cmdWe <= 1'b1;
                end else begin
                  strobe.memWe  <= 1'b1;
                  strobe.ptrInc <= 1'b1;
                end
                firstByte <= 1'b0;
                driveLow  <= 1'b1;
                state     <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                shiftReg      <= rdData;
                strobe.ptrInc <= 1'b1;
                driveLow      <= ~rdData[BYTE_W-1];
                state         <= ST_TX;
              end else begin
                driveLow <= 1'b0;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                driveLow <= 1'b0;
                state    <= ST_RACK;
              end else begin
                shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
                driveLow <= ~shiftReg[BYTE_W-2];
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              masterAck <= ~sdaNow;
            end else if (sclFall) begin
              bitCnt <= '0;
              if (masterAck) begin
                shiftReg      <= rdData;
                strobe.ptrInc <= 1'b1;
                driveLow      <= ~rdData[BYTE_W-1];
                state         <= ST_TX;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = driveLow;

  // R2: the slave only moves SDA while the synchronised SCL is low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((driveLow != $past(driveLow)) && !$past(startDet) && !$past(stopDet)) |-> !sclNow);

  // R3: an ignored transfer never pulls SDA low
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !driveLow);

  // R5: at most one kind of write per cycle
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdWe, strobe.memWe}));

  // R10: after the host declines a byte the slave goes quiet
  assert_nack_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RACK && state == ST_SKIP) |-> !driveLow);
endmodule

// File: rtl/disp_i2c_dp.sv
module disp_i2c_dp
  import disp_i2c_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobe_t              strobe,
  output logic [BYTE_W-1:0]       rdData,
  output logic                    dispOff,
  output logic [1:0]              frameSel,
  output logic                    blinkSel,
  output logic [PTR_W-1:0]        ptr,
  output logic [DEPTH*BYTE_W-1:0] memQ
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam int               MEM_W    = DEPTH * BYTE_W;

  logic [PTR_W-1:0] ptrNext;
  logic [PTR_W-1:0] ptrLoad;

  assign ptrNext = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
  assign ptrLoad = (int'(strobe.wrData[PTR_W-1:0]) < DEPTH) ? strobe.wrData[PTR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispOff  <= 1'b0;
      frameSel <= '0;
      blinkSel <= 1'b0;
      ptr      <= '0;
    end else if (strobe.cmdWe) begin
      dispOff  <= strobe.wrData[7];
      frameSel <= strobe.wrData[6:5];
      blinkSel <= strobe.wrData[4];
      ptr      <= ptrLoad;
    end else if (strobe.ptrInc) begin
      ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ <= '0;
    end else if (strobe.memWe) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ptr == PTR_W'(i)) memQ[i*BYTE_W +: BYTE_W] <= strobe.wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr == PTR_W'(i)) rdData = memQ[i*BYTE_W +: BYTE_W];
    end
  end

  // R7: the pointer never addresses past the memory
  assert_ptr_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) < DEPTH);

  // R6: stepping from the last location lands on location 0
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.ptrInc) && !$past(strobe.cmdWe) && $past(ptr) == LAST_PTR) |-> ptr == '0);

  // R3: memory only changes on a data write
  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.memWe) |-> memQ == $past(memQ));

  // R4: a mode byte lands in the mode fields
  assert_cmd_fields_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.cmdWe) |-> {dispOff, frameSel, blinkSel} == $past(strobe.wrData[7:4]));

  logic [MEM_W-1:0] unusedW;
  assign unusedW = memQ;
endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111001,
  parameter int         DEPTH    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaDriveLow,
  output logic                    dispOff,
  output logic [1:0]              frameSel,
  output logic                    blinkSel,
  output logic [PTR_W-1:0]        memPtr,
  output logic [DEPTH*BYTE_W-1:0] memFlat
);
  busStrobe_t        strobe;
  logic [BYTE_W-1:0] rdData;

  disp_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rdData     (rdData),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  disp_i2c_dp #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdData  (rdData),
    .dispOff (dispOff),
    .frameSel(frameSel),
    .blinkSel(blinkSel),
    .ptr     (memPtr),
    .memQ    (memFlat)
  );
endmodule

// File: tb/tb_disp_i2c_slave.sv
module tb_disp_i2c_slave;
  localparam int Q = 10;
  localparam int DEPTH = 12;
  localparam logic [7:0] ADDR_W = 8'h72;
  localparam logic [7:0] ADDR_R = 8'h73;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSdaLow = 1'b0;
  logic sdaBus;
  logic sdaDriveLow, dispOff, blinkSel;
  logic [1:0] frameSel;
  logic [3:0] memPtr;
  logic [DEPTH*8-1:0] memFlat;

  int total = 0;
  int bad = 0;
  int model [DEPTH];
  int modelPtr = 0;

  always #5 clk = ~clk;
  assign sdaBus = !(mSdaLow || sdaDriveLow);

  disp_i2c_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .dispOff(dispOff), .frameSel(frameSel),
    .blinkSel(blinkSel), .memPtr(memPtr), .memFlat(memFlat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart;
    mSdaLow = 1'b0; waitQ;
    scl = 1'b1; waitQ;
    mSdaLow = 1'b1; waitQ;
    scl = 1'b0; waitQ;
  endtask

  task automatic i2cStop;
    mSdaLow = 1'b1; waitQ;
    scl = 1'b1; waitQ;
    mSdaLow = 1'b0; waitQ;
    waitQ;
  endtask

  task automatic sendBit(input logic b);
    mSdaLow = !b; waitQ;
    scl = 1'b1; waitQ; waitQ;
    scl = 1'b0; waitQ;
  endtask

  task automatic recvBit(output logic b);
    mSdaLow = 1'b0; waitQ;
    scl = 1'b1; waitQ;
    b = sdaBus; waitQ;
    scl = 1'b0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  task automatic checkMem(input string tag);
    for (int i = 0; i < DEPTH; i++) chk(tag, int'(memFlat[i*8 +: 8]), model[i]);
  endtask

  initial begin
    logic ack;
    logic [7:0] cmd, rd;
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 dispOff", int'(dispOff), 0);
    chk("R1 frameSel", int'(frameSel), 0);
    chk("R1 blinkSel", int'(blinkSel), 0);
    chk("R1 memPtr", int'(memPtr), 0);
    chk("R1 sdaDriveLow", int'(sdaDriveLow), 0);
    checkMem("R1 memory");
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4 and R7: every pointer value, upper fields varying
    for (int c = 0; c < 16; c++) begin
      cmd = 8'(((c * 5) & 15) << 4) | 8'(c);
      i2cStart;
      sendByte(ADDR_W, ack); chk("R2 address ack", int'(ack), 1);
      sendByte(cmd, ack);    chk("R2 mode byte ack", int'(ack), 1);
      i2cStop;
      chk("R4 dispOff", int'(dispOff), int'(cmd[7]));
      chk("R4 frameSel", int'(frameSel), int'(cmd[6:5]));
      chk("R4 blinkSel", int'(blinkSel), int'(cmd[4]));
      modelPtr = (c < DEPTH) ? c : 0;
      chk("R7 pointer load", int'(memPtr), modelPtr);
    end

    // R5, R11, R6: fill all bytes from pointer 0
    i2cStart;
    sendByte(ADDR_W, ack);
    sendByte(8'h00, ack);
    modelPtr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int v;
      v = (i * 29 + 17) & 255;
      sendByte(8'(v), ack); chk("R2 data ack", int'(ack), 1);
      model[modelPtr] = v;
      modelPtr = (modelPtr + 1) % DEPTH;
    end
    i2cStop;
    checkMem("R5 R11 fill");
    chk("R6 pointer after full fill", int'(memPtr), modelPtr);

    // R6: write crossing the wrap
    i2cStart;
    sendByte(ADDR_W, ack);
    sendByte(8'h0A, ack);
    modelPtr = 10;
    for (int i = 0; i < 4; i++) begin
      sendByte(8'(8'hA0 + i), ack);
      model[modelPtr] = 8'hA0 + i;
      modelPtr = (modelPtr + 1) % DEPTH;
    end
    i2cStop;
    checkMem("R6 wrap write");
    chk("R6 pointer after wrap", int'(memPtr), 2);

    // R8, R10: combined read from every start pointer
    for (int p = 0; p < DEPTH; p++) begin
      i2cStart;
      sendByte(ADDR_W, ack);
      sendByte(8'(p), ack);
      i2cStart;
      sendByte(ADDR_R, ack); chk("R2 read address ack", int'(ack), 1);
      for (int k = 0; k < 3; k++) begin
        recvByte(rd, k != 2);
        chk("R8 combined read", int'(rd), model[(p + k) % DEPTH]);
      end
      i2cStop;
      chk("R10 pointer after read", int'(memPtr), (p + 3) % DEPTH);
      chk("R10 SDA released", int'(sdaDriveLow), 0);
    end
    modelPtr = (DEPTH - 1 + 3) % DEPTH;

    // R9: direct read from the left-over pointer
    i2cStart;
    sendByte(ADDR_R, ack);
    recvByte(rd, 1'b1); chk("R9 direct read first", int'(rd), model[modelPtr]);
    recvByte(rd, 1'b0); chk("R9 direct read second", int'(rd), model[(modelPtr + 1) % DEPTH]);
    i2cStop;
    modelPtr = (modelPtr + 2) % DEPTH;
    chk("R10 pointer after direct read", int'(memPtr), modelPtr);

    // R3: foreign write address
    cmd = {dispOff, frameSel, blinkSel, memPtr};
    i2cStart;
    sendByte(8'h3A, ack); chk("R3 foreign address nack", int'(ack), 0);
    sendByte(8'h00, ack); chk("R3 foreign data nack", int'(ack), 0);
    sendByte(8'hFF, ack);
    i2cStop;
    checkMem("R3 memory untouched");
    chk("R3 mode untouched", int'({dispOff, frameSel, blinkSel, memPtr}), int'(cmd));

    // R3: foreign read address leaves the line high
    i2cStart;
    sendByte(8'h75, ack); chk("R3 foreign read nack", int'(ack), 0);
    recvByte(rd, 1'b0); chk("R3 foreign read idle line", int'(rd), 255);
    i2cStop;
    chk("R3 pointer untouched", int'(memPtr), modelPtr);

    // R3: a repeated start after a foreign address is served
    i2cStart;
    sendByte(8'h3A, ack);
    i2cStart;
    sendByte(ADDR_W, ack); chk("R3 served after restart", int'(ack), 1);
    sendByte(8'hB5, ack);
    sendByte(8'h5C, ack);
    i2cStop;
    model[5] = 8'h5C;
    chk("R3 R4 dispOff after restart", int'(dispOff), 1);
    chk("R3 R4 frameSel after restart", int'(frameSel), 1);
    chk("R3 R4 blinkSel after restart", int'(blinkSel), 1);
    chk("R5 pointer after one byte", int'(memPtr), 6);
    checkMem("R5 single byte at 5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule